// File: doc/BRIEF.md
# Saturating Fixed-Point Multiply-Accumulate Unit

This block computes dot products of the kind used by FIR filters, working on signed fractional fixed-point numbers. On each accepted tap it multiplies one coefficient by one sample. The multiply and the add happen in the same cycle. The tap flagged as first loads its product straight into the accumulator, so no cycle is spent clearing it. Every later tap of the same run adds its product to the running sum. A run of N taps therefore takes N accepted multiply-accumulate operations.

The accumulator carries guard bits, so a partial sum may leave the output range and come back without harm. Only the final sum is narrowed to the output width. If that final sum cannot be represented, the result is clamped to the largest value of the same sign. Nothing traps or stalls when this happens. A sticky flag records the clamp, and the next first tap clears it.

A one-cycle done pulse marks the cycle in which a new result appears. The result then holds until the following done.

Top module: `mac_sat_top`

## Requirements
- R1: Operands are W-bit two's-complement fractions: the MSB weighs -1 and the next bit 1/2. The result is a (2W-1)-bit fraction whose LSB weighs 2^-(2W-2). With the default W=8, a single-tap run returns coef*samp as a signed integer, for example 64*64 gives 4096.
- R2: A tap with `tap_first` high loads its product into the accumulator. Nothing left over from an earlier run contributes to the new sum.
- R3: Each later accepted tap of a run adds its product to the running sum, in the same cycle as its multiply.
- R4: A final sum above the largest output value gives 2^(2W-2)-1 (16383 by default). A final sum below the smallest gives -2^(2W-2) (-16384 by default). No wrap-around ever occurs.
- R5: Partial sums that leave the output range are kept exactly, provided the final sum lies inside the range. In that case the result is exact and no clamp is flagged.
- R6: `done` is high for exactly one cycle, in the cycle after the last tap of a run is accepted. `result` changes only together with `done`.
- R7: The tap count is sampled from `tap_cnt` with the first tap. A value of 0 is treated as 1.
- R8: `ovf` goes high together with a clamped result. It stays high until the next first tap is accepted, which clears it.
- R9: Cycles with `tap_vld` low are skipped and leave the run intact. A tap that is not first, arriving while no run is open, is ignored.
- R10: A first tap that arrives while a run is open abandons that run and starts a new one.
- R11: After reset, `done`, `ovf` and `busy` are low and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tap_vld | input | 1 | A coefficient and sample pair is offered this cycle |
| tap_first | input | 1 | The offered pair is the first tap of a run |
| tap_cnt | input | TAP_W | Number of taps in the run, sampled with the first tap (0 means 1) |
| coef | input | W | Coefficient, signed fraction |
| samp | input | W | Sample, signed fraction |
| busy | output | 1 | A run is open and waits for further taps |
| done | output | 1 | One-cycle pulse: a new result is valid |
| result | output | 2W-1 | Saturated dot product, signed fraction |
| ovf | output | 1 | Sticky flag: the latest result was clamped |

## Verification
The hardest case to reach from the ports is a run whose partial sums leave the output range and then return to it. Only the guard bits keep such a run from either wrapping or clamping too early, and its final value reveals neither failure unless the path through the range is chosen with care. The stimulus reaches this case with a run of three near-maximum positive products followed by two large negative products. The sum climbs to about three times full scale and ends just inside the range. The exact value and a low `ovf` are then checked. Restarting a run mid-way and clearing a set `ovf` are reached by directed sequences that overlap runs.

// File: rtl/mac_pkg.sv
package mac_pkg;
  typedef enum logic {
    RUN_IDLE = 1'b0,
    RUN_OPEN = 1'b1
  } run_st_e;
endpackage

// File: rtl/mac_mul.sv
module mac_mul #(
  parameter int W = 8,
  localparam int PW = 2 * W
) (
  input  logic signed [W-1:0]  a,
  input  logic signed [W-1:0]  b,
  output logic signed [PW-1:0] prod
);
  // Full-precision signed product; 2W bits so that -1 * -1 = +1 fits.
  function automatic logic signed [PW-1:0] frac_mul(input logic signed [W-1:0] x,
                                                    input logic signed [W-1:0] y);
    logic signed [PW-1:0] xe, ye;
    xe = PW'(x);
    ye = PW'(y);
    return xe * ye;
  endfunction

  always_comb prod = frac_mul(a, b);
endmodule

// File: rtl/mac_ctl.sv
module mac_ctl
  import mac_pkg::*;
#(
  parameter int TAP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tap_vld,
  input  logic             tap_first,
  input  logic [TAP_W-1:0] tap_cnt,
  output logic             take,
  output logic             seed,
  output logic             last,
  output logic             busy
);
  run_st_e          st_q, st_d;
  logic [TAP_W-1:0] cnt_q, cnt_d;
  logic [TAP_W-1:0] lim_q, lim_d;
  logic [TAP_W-1:0] lim_in;
  logic [TAP_W-1:0] cnt_inc;

  always_comb lim_in = (tap_cnt == '0) ? TAP_W'(1) : tap_cnt;
  always_comb cnt_inc = cnt_q + TAP_W'(1);

  always_comb begin
    seed = tap_vld && tap_first;
    take = seed || (tap_vld && (st_q == RUN_OPEN));
    if (seed)        last = (lim_in == TAP_W'(1));
    else if (take)   last = (cnt_inc == lim_q);
    else             last = 1'b0;
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    lim_d = lim_q;
    if (seed) begin
      lim_d = lim_in;
      cnt_d = TAP_W'(1);
      st_d  = last ? RUN_IDLE : RUN_OPEN;
    end else if (take) begin
      cnt_d = cnt_inc;
      if (last) st_d = RUN_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RUN_IDLE;
      cnt_q <= '0;
      lim_q <= TAP_W'(1);
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      lim_q <= lim_d;
    end
  end

  always_comb busy = (st_q == RUN_OPEN);
endmodule

// File: rtl/mac_acc.sv
module mac_acc #(
  parameter int PW    = 16,
  parameter int ACC_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    take,
  input  logic                    seed,
  input  logic signed [PW-1:0]    prod,
  output logic signed [ACC_W-1:0] sum_nxt
);
  logic signed [ACC_W-1:0] acc_q;
  logic signed [ACC_W-1:0] prod_x;

  // Sign-extend the product into the guarded accumulator width.
  function automatic logic signed [ACC_W-1:0] widen(input logic signed [PW-1:0] p);
    return {{(ACC_W-PW){p[PW-1]}}, p};
  endfunction

  always_comb begin
    prod_x  = widen(prod);
    sum_nxt = seed ? prod_x : (acc_q + prod_x);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    acc_q <= '0;
    else if (take) acc_q <= sum_nxt;
  end
endmodule

// File: rtl/mac_narrow.sv
module mac_narrow #(
  parameter int ACC_W = 20,
  parameter int OUT_W = 15
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    last,
  input  logic                    seed,
  input  logic signed [ACC_W-1:0] sum_nxt,
  output logic                    sat_evt,
  output logic                    done,
  output logic signed [OUT_W-1:0] result,
  output logic                    ovf
);
  localparam int HI_W = ACC_W - OUT_W + 1;

  logic [HI_W-1:0]         hi;
  logic                    fits;
  logic signed [OUT_W-1:0] clamped;

  // The sum fits when every bit above the output sign bit copies it.
  function automatic logic signed [OUT_W-1:0] clamp(input logic signed [ACC_W-1:0] v,
                                                    input logic ok);
    logic signed [OUT_W-1:0] r;
    if (ok)                r = v[OUT_W-1:0];
    else if (v[ACC_W-1])   r = {1'b1, {(OUT_W-1){1'b0}}};
    else                   r = {1'b0, {(OUT_W-1){1'b1}}};
    return r;
  endfunction

  always_comb begin
    hi      = sum_nxt[ACC_W-1:OUT_W-1];
    fits    = (&hi) || !(|hi);
    clamped = clamp(sum_nxt, fits);
    sat_evt = last && !fits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done   <= 1'b0;
      result <= '0;
      ovf    <= 1'b0;
    end else begin
      done <= last;
      if (last) begin
        result <= clamped;
        ovf    <= !fits;
      end else if (seed) begin
        ovf <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mac_sat_top.sv
module mac_sat_top #(
  parameter int W     = 8,
  parameter int TAP_W = 4,
  localparam int PW    = 2 * W,
  localparam int OUT_W = 2 * W - 1,
  localparam int ACC_W = OUT_W + TAP_W + 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tap_vld,
  input  logic                    tap_first,
  input  logic [TAP_W-1:0]        tap_cnt,
  input  logic signed [W-1:0]     coef,
  input  logic signed [W-1:0]     samp,
  output logic                    busy,
  output logic                    done,
  output logic signed [OUT_W-1:0] result,
  output logic                    ovf
);
  logic                    take_w;
  logic                    seed_w;
  logic                    last_w;
  logic                    sat_w;
  logic signed [PW-1:0]    prod_w;
  logic signed [ACC_W-1:0] sum_w;

  mac_ctl #(.TAP_W(TAP_W)) u_ctl (
    .clk(clk), .rst_n(rst_n), .tap_vld(tap_vld), .tap_first(tap_first),
    .tap_cnt(tap_cnt), .take(take_w), .seed(seed_w), .last(last_w), .busy(busy)
  );

  mac_mul #(.W(W)) u_mul (
    .a(coef), .b(samp), .prod(prod_w)
  );

  mac_acc #(.PW(PW), .ACC_W(ACC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .take(take_w), .seed(seed_w),
    .prod(prod_w), .sum_nxt(sum_w)
  );

  mac_narrow #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_nar (
    .clk(clk), .rst_n(rst_n), .last(last_w), .seed(seed_w), .sum_nxt(sum_w),
    .sat_evt(sat_w), .done(done), .result(result), .ovf(ovf)
  );
endmodule

// File: rtl/mac_sat_chk.sv
module mac_sat_chk #(
  parameter int OUT_W = 15
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    tap_vld,
  input logic                    tap_first,
  input logic                    busy,
  input logic                    done,
  input logic signed [OUT_W-1:0] result,
  input logic                    ovf,
  input logic                    seed,
  input logic                    last,
  input logic                    sat_evt
);
  localparam logic signed [OUT_W-1:0] OMAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] OMIN = {1'b1, {(OUT_W-1){1'b0}}};

  // R6
  last_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last |=> done);

  // R6
  done_needs_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(tap_vld));

  // R6
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

  // R4
  clamp_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && ovf) |-> (result == OMAX || result == OMIN));

  // R8
  ovf_follows_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sat_evt |=> ovf);

  // R8
  ovf_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (seed && !last) |=> !ovf);

  // R9
  idle_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tap_vld && !tap_first) |=> !done);

  // R10
  done_closes_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
endmodule

bind mac_sat_top mac_sat_chk #(.OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tap_vld(tap_vld), .tap_first(tap_first),
  .busy(busy), .done(done), .result(result), .ovf(ovf),
  .seed(seed_w), .last(last_w), .sat_evt(sat_w)
);

// File: tb/tb_mac_sat_top.sv
`timescale 1ns/1ps
module tb_mac_sat_top;
  localparam int W = 8;
  localparam int TAP_W = 4;
  localparam int OUT_W = 2 * W - 1;
  localparam int NV = 8;

  // vector table: tap count, coef, sample (same pair every tap), expected result, expected ovf
  localparam int TV_N[NV]   = '{1, 3, 4, 1, 2, 5, 2, 0};
  localparam int TV_A[NV]   = '{64, 64, 64, -128, -128, 10, -128, 100};
  localparam int TV_B[NV]   = '{64, -64, 64, -128, 127, -3, -128, 100};
  localparam int TV_E[NV]   = '{4096, -12288, 16383, 16383, -16384, -150, 16383, 10000};
  localparam int TV_O[NV]   = '{0, 0, 1, 1, 1, 0, 1, 0};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tap_vld = 1'b0;
  logic tap_first = 1'b0;
  logic [TAP_W-1:0] tap_cnt = '0;
  logic signed [W-1:0] coef = '0;
  logic signed [W-1:0] samp = '0;
  logic busy, done, ovf;
  logic signed [OUT_W-1:0] result;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  mac_sat_top #(.W(W), .TAP_W(TAP_W)) dut (
    .clk(clk), .rst_n(rst_n), .tap_vld(tap_vld), .tap_first(tap_first),
    .tap_cnt(tap_cnt), .coef(coef), .samp(samp),
    .busy(busy), .done(done), .result(result), .ovf(ovf)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(input bit f, input int n, input int a, input int b);
    @(negedge clk);
    tap_vld = 1'b1;
    tap_first = f;
    tap_cnt = n[TAP_W-1:0];
    coef = a[W-1:0];
    samp = b[W-1:0];
    @(posedge clk);
    #1;
    tap_vld = 1'b0;
    tap_first = 1'b0;
  endtask

  task automatic chk_res(input string tag, input int exp_r, input int exp_o);
    @(negedge clk);
    chk(done == 1'b1, {tag, " done"}, int'(done), 1);
    chk(int'(result) == exp_r, {tag, " result"}, int'(result), exp_r);
    chk(int'(ovf) == exp_o, {tag, " ovf"}, int'(ovf), exp_o);
    @(negedge clk);
    // R6: single-cycle pulse
    chk(done == 1'b0, {tag, " R6 done drop"}, int'(done), 0);
  endtask

  initial begin
    #(4 * 100000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(done == 1'b0, "R11 done", int'(done), 0);
    chk(ovf == 1'b0, "R11 ovf", int'(ovf), 0);
    chk(busy == 1'b0, "R11 busy", int'(busy), 0);
    chk(result == '0, "R11 result", int'(result), 0);
    rst_n = 1'b1;

    // R1 R2 R3 R4 R7 R8 table walk
    for (int v = 0; v < NV; v++) begin
      int nt;
      nt = (TV_N[v] == 0) ? 1 : TV_N[v];
      for (int t = 0; t < nt; t++) put(t == 0, TV_N[v], TV_A[v], TV_B[v]);
      chk_res($sformatf("R1/R3/R4/R7 vec%0d", v), TV_E[v], TV_O[v]);
    end

    // R5: partial sums exceed range, final back inside
    put(1, 5, 127, 127);
    put(0, 5, 127, 127);
    put(0, 5, 127, 127);
    put(0, 5, -128, 127);
    put(0, 5, -128, 127);
    chk_res("R5 guard", 15875, 0);

    // R9: gaps keep the run open
    put(1, 2, 64, 64);
    repeat (3) @(negedge clk);
    chk(busy == 1'b1, "R9 gap busy", int'(busy), 1);
    chk(done == 1'b0, "R9 gap done", int'(done), 0);
    put(0, 2, 64, 64);
    chk_res("R9 gap", 8192, 0);

    // R9: non-first tap while idle ignored
    put(0, 1, 100, 100);
    @(negedge clk);
    chk(done == 1'b0, "R9 idle done", int'(done), 0);
    chk(int'(result) == 8192, "R9 idle result", int'(result), 8192);

    // R10 and R2: restart mid-run
    put(1, 3, 127, 127);
    put(0, 3, 127, 127);
    put(1, 2, 10, 10);
    put(0, 2, 10, 10);
    chk_res("R10 restart", 200, 0);

    // R8: sticky flag cleared by next first tap
    put(1, 2, -128, -128);
    put(0, 2, -128, -128);
    chk_res("R8 set", 16383, 1);
    put(1, 2, 1, 1);
    @(negedge clk);
    chk(ovf == 1'b0, "R8 clear", int'(ovf), 0);
    chk(int'(result) == 16383, "R6 hold", int'(result), 16383);
    put(0, 2, 1, 1);
    chk_res("R8 after", 2, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule